// File: doc/BRIEF.md
# Bit-Stuffed Serial Configuration Receiver

This block takes configuration from a two-wire serial link (a serial clock and a data line) and keeps two registers up to date: an 8-bit control register and a 22-bit program register. The design runs on its own system clock. It brings both serial wires through a synchronizer and takes one data bit on each rising edge of the serial clock it sees there. Words are sent least-significant bit first.

A frame marker closes each control byte. The marker is a 0, then four 1s, then a 0. A run of four 1s occurs nowhere else, because the sender places a 0 after every three 1s in a row in ordinary data. The receiver removes those zeros again. When the marker is recognised, the eight data bits just before its leading 0 become the new control value at once. Bit 0 of the control register opens and closes the collection of program bits. The program register is not written as bits arrive. It is written only when a control write drops bit 0 from 1 to 0, and it then takes the 22 data bits that came before that control byte. On that write a one-cycle load strobe is given.

The receive engine is a five-state machine. The states are:
- ST_DATA: no 1s seen yet.
- ST_RUN1: one 1 seen.
- ST_RUN2: two 1s seen.
- ST_RUN3: three 1s seen, and a stuffed 0 or a marker is due next.
- ST_TAIL: the marker's closing bit is due.

Transitions happen only on a serial bit:
- From ST_DATA, ST_RUN1 or ST_RUN2, a 1 moves one state along the run. A 0 returns to ST_DATA. Both bits are kept as data.
- In ST_RUN3, a 0 is the stuffed bit. It is discarded and the engine goes to ST_DATA.
- In ST_RUN3, a 1 is the marker hit. The engine goes to ST_TAIL.
- In ST_TAIL, any bit is discarded and the engine goes back to ST_DATA.

Top module: `stuffed_cfg_rx`

## Requirements
- R1: A data bit is taken only on a rising edge of the serial clock. Words are assembled least-significant bit first, so the first data bit of a control byte lands in control bit 0.
- R2: A 0 that follows three consecutive 1s of data is removed and never counted as a data bit. The raw stream 10110001001001101110000, sent from its rightmost character, yields the 22-bit word 1011000_1_001_0011111_0000.
- R3: The fourth consecutive 1 marks a frame. The eight data bits received before the frame's leading 0 are copied into the control register.
- R4: The bit after a frame's fourth 1 is discarded. The run count and the collected-bit count restart after every frame, so 1s before a frame and 1s after it never join into one run.
- R5: After reset the control register holds 0x04, the program register holds 0, and the load strobe is low.
- R6: While control bit 0 is 0, no program bits are collected. A control write then leaves the program register unchanged.
- R7: A frame whose control byte has bit 0 = 0, while the present control bit 0 is 1, copies into the program register the 22 data bits that came before that control byte. The last of those bits becomes bit 21.
- R8: The load strobe is high for exactly one system clock, in the cycle the program register takes its new value. No strobe follows a control write that does not change bit 0 from 1 to 0.
- R9: A change on the data line while the serial clock does not rise has no effect on the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial clock; a bit is taken on its rising edge |
| ser_data | input | 1 | Serial data line |
| ctrl_o | output | 8 | Control register |
| prog_o | output | 22 | Program register |
| load_o | output | 1 | One-cycle strobe when the program register is written |

## Verification
The bench uses several kinds of stream:
- A raw, already stuffed stream. This shows that the removal of stuffed zeros gives the stated word, independent of the bench's own stuffer.
- Control bytes dense in 1s (0xF7, 0xF6), which need stuffing inside the byte and just before the marker. These separate a correct run count from one that is off by one.
- An all-ones program word, which needs the most stuffing.
- Writes that keep bit 0 at 1, writes with bit 0 at 0 before the next write, and data sent while collection is off. These tell a correct commit condition apart from a commit on every frame.
- A byte ending in 1s followed by a byte starting with 1s. This shows that the run count restarts after a frame.
- Data-line glitches with the serial clock held low. These show that only serial clock edges matter.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int SCR_CTRL_W   = 8;
    localparam int SCR_PROG_W   = 22;
    // data bits pushed after the control byte before a marker is known:
    // the leading zero and three ones
    localparam int SCR_LAG_W    = 4;
    localparam logic [SCR_CTRL_W-1:0] SCR_CTRL_RST = 8'h04;

    typedef enum logic [2:0] {
        ST_DATA = 3'd0,
        ST_RUN1 = 3'd1,
        ST_RUN2 = 3'd2,
        ST_RUN3 = 3'd3,
        ST_TAIL = 3'd4
    } scr_state_e;

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_data,
    output logic rise_o,
    output logic bit_o
);

    logic [STAGES-1:0] clk_sh;
    logic [STAGES-1:0] dat_sh;
    logic              clk_prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        clk_sh[0] <= 1'b0;
                        dat_sh[0] <= 1'b0;
                    end else begin
                        clk_sh[0] <= ser_clk;
                        dat_sh[0] <= ser_data;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        clk_sh[g] <= 1'b0;
                        dat_sh[g] <= 1'b0;
                    end else begin
                        clk_sh[g] <= clk_sh[g-1];
                        dat_sh[g] <= dat_sh[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= clk_sh[STAGES-1];
    end

    assign rise_o = clk_sh[STAGES-1] & ~clk_prev;
    assign bit_o  = dat_sh[STAGES-1];

endmodule

// File: rtl/scr_fsm.sv
module scr_fsm
    import scr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    input  logic       bit_i,
    output logic       push_o,
    output logic       frame_o,
    output scr_state_e state_o
);

    scr_state_e state_q;
    scr_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DATA;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (rise_i) begin
            unique case (state_q)
                ST_DATA: state_d = bit_i ? ST_RUN1 : ST_DATA;
                ST_RUN1: state_d = bit_i ? ST_RUN2 : ST_DATA;
                ST_RUN2: state_d = bit_i ? ST_RUN3 : ST_DATA;
                ST_RUN3: state_d = bit_i ? ST_TAIL : ST_DATA;
                ST_TAIL: state_d = ST_DATA;
                default: state_d = ST_DATA;
            endcase
        end
    end

    // outputs
    always_comb begin
        push_o  = 1'b0;
        frame_o = 1'b0;
        if (rise_i) begin
            unique case (state_q)
                ST_DATA, ST_RUN1, ST_RUN2: push_o = 1'b1;
                ST_RUN3:                   frame_o = bit_i;
                ST_TAIL:                   push_o = 1'b0;
                default:                   push_o = 1'b0;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/scr_store.sv
module scr_store
    import scr_pkg::*;
#(
    parameter int                CTRL_W   = SCR_CTRL_W,
    parameter int                PROG_W   = SCR_PROG_W,
    parameter int                LAG_W    = SCR_LAG_W,
    parameter logic [CTRL_W-1:0] CTRL_RST = SCR_CTRL_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              frame_i,
    input  logic              bit_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [PROG_W-1:0] prog_o,
    output logic [PROG_W-1:0] shadow_o,
    output logic              load_o
);

    localparam int WIN_W = CTRL_W + LAG_W;
    localparam int CNT_W = $clog2(WIN_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WIN_W);

    logic [WIN_W-1:0]  win_q;
    logic [CNT_W-1:0]  fill_q;
    logic [PROG_W-1:0] shadow_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [PROG_W-1:0] prog_q;
    logic              load_q;
    logic              spill;
    logic              commit;

    // a bit leaves the window only once it holds a full control byte and lag
    assign spill  = push_i && (fill_q == FULL) && ctrl_q[0];
    assign commit = frame_i && ctrl_q[0] && !win_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (frame_i) begin
            fill_q <= '0;
        end else if (push_i) begin
            win_q <= {bit_i, win_q[WIN_W-1:1]};
            if (fill_q != FULL) fill_q <= fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     shadow_q <= '0;
        else if (spill) shadow_q <= {win_q[0], shadow_q[PROG_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            prog_q <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= commit;
            if (frame_i) ctrl_q <= win_q[CTRL_W-1:0];
            if (commit)  prog_q <= shadow_q;
        end
    end

    assign ctrl_o   = ctrl_q;
    assign prog_o   = prog_q;
    assign shadow_o = shadow_q;
    assign load_o   = load_q;

endmodule

// File: rtl/stuffed_cfg_rx.sv
module stuffed_cfg_rx
    import scr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CTRL_W      = SCR_CTRL_W,
    parameter int PROG_W      = SCR_PROG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [PROG_W-1:0] prog_o,
    output logic              load_o
);

    logic              rise_w;
    logic              bit_w;
    logic              push_w;
    logic              frame_w;
    scr_state_e        state_w;
    logic [PROG_W-1:0] shadow_w;

    scr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .rise_o   (rise_w),
        .bit_o    (bit_w)
    );

    scr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_w),
        .bit_i   (bit_w),
        .push_o  (push_w),
        .frame_o (frame_w),
        .state_o (state_w)
    );

    scr_store #(
        .CTRL_W   (CTRL_W),
        .PROG_W   (PROG_W),
        .LAG_W    (SCR_LAG_W),
        .CTRL_RST (CTRL_W'(SCR_CTRL_RST))
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_w),
        .frame_i  (frame_w),
        .bit_i    (bit_w),
        .ctrl_o   (ctrl_o),
        .prog_o   (prog_o),
        .shadow_o (shadow_w),
        .load_o   (load_o)
    );

endmodule

// File: rtl/scr_chk.sv
module scr_chk
    import scr_pkg::*;
#(
    parameter int CTRL_W = SCR_CTRL_W,
    parameter int PROG_W = SCR_PROG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              sbit,
    input  scr_state_e        state,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [PROG_W-1:0] prog,
    input  logic [PROG_W-1:0] shadow,
    input  logic              load
);

    AST_CTRL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl != $past(ctrl)) |-> $past(rise)); // R1

    AST_STUFF_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !sbit && state == ST_RUN3) |=> (state == ST_DATA && $stable(ctrl))); // R2

    AST_TAIL_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && state == ST_TAIL) |=> (state == ST_DATA)); // R4

    AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl[0]) |-> $stable(shadow)); // R6

    AST_PROG_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (prog != $past(prog)) |-> load); // R7

    AST_LOAD_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!ctrl[0] && $past(ctrl[0]))); // R8

    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load); // R8

endmodule

bind stuffed_cfg_rx scr_chk #(.CTRL_W(CTRL_W), .PROG_W(PROG_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (rise_w),
    .sbit   (bit_w),
    .state  (state_w),
    .ctrl   (ctrl_o),
    .prog   (prog_o),
    .shadow (shadow_w),
    .load   (load_o)
);

// File: tb/test_stuffed_cfg_rx.sv
`timescale 1ns/1ps
module test_stuffed_cfg_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [7:0]  ctrl_o;
    logic [21:0] prog_o;
    logic        load_o;

    int errs = 0;
    int checks = 0;
    int loads_seen = 0;
    bit done = 0;

    // behavioural model state
    bit          dq[$];
    int          ones = 0;
    logic [7:0]  exp_ctrl = 8'h04;
    logic [21:0] exp_prog = '0;
    int          exp_loads = 0;

    always #2.5 clk = ~clk;

    stuffed_cfg_rx i_stuffed_cfg_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ctrl_o   (ctrl_o),
        .prog_o   (prog_o),
        .load_o   (load_o)
    );

    always @(negedge clk) if (rst_n && load_o) loads_seen++;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        @(negedge clk);
        chk(req, "ctrl", ctrl_o, exp_ctrl);
        chk(req, "prog", prog_o, exp_prog);
        chk(req, "loads", loads_seen, exp_loads);
    endtask

    task automatic send_raw(bit b);
        @(negedge clk);
        ser_data = b;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (8) @(negedge clk);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_data(bit b);
        send_raw(b);
        dq.push_back(b);
        if (b) ones++; else ones = 0;
        if (ones == 3) begin
            send_raw(1'b0);
            ones = 0;
        end
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data(v[i]);
    endtask

    task automatic send_word(logic [21:0] v);
        for (int i = 0; i < 22; i++) send_data(v[i]);
    endtask

    task automatic send_frame();
        logic [7:0] nb;
        int n;
        send_raw(1'b0);
        for (int i = 0; i < 4; i++) send_raw(1'b1);
        send_raw(1'b0);
        n = dq.size();
        for (int i = 0; i < 8; i++) nb[i] = dq[n-8+i];
        if (exp_ctrl[0] && !nb[0] && n >= 30) begin
            for (int i = 0; i < 22; i++) exp_prog[i] = dq[n-30+i];
            exp_loads++;
        end
        exp_ctrl = nb;
        dq.delete();
        ones = 0;
        repeat (8) @(negedge clk);
    endtask

    task automatic glitch_data();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ser_data = ~ser_data;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [22:0] raw;
        logic [21:0] word;
        raw  = 23'b10110001001001101110000;
        word = 22'b1011000_1_001_0011111_0000;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R5: reset values
        check_all("R5");

        // R1 R3: enable collection, mux bit set
        send_byte(8'h05); send_frame();
        check_all("R1 R3");

        // R2 R7 R8: pre-stuffed raw stream, sent rightmost first
        for (int i = 0; i < 23; i++) send_raw(raw[i]);
        for (int i = 0; i < 22; i++) dq.push_back(word[i]);
        ones = 1;
        send_byte(8'h04); send_frame();
        check_all("R2 R7 R8");
        @(negedge clk);
        chk("R2", "literal word", prog_o, word);

        // R6: collection disabled, write with bit0 = 0
        send_word(22'h2A5C31); send_byte(8'h00); send_frame();
        check_all("R6");

        // R2 R3: dense ones in the control byte, enable
        send_byte(8'hF7); send_frame();
        check_all("R2 R3");

        // R2 R7: all-ones program word, commit with dense byte
        send_word(22'h3FFFFF); send_byte(8'hF6); send_frame();
        check_all("R2 R7 R8");

        // R8: bit0 stays 1, no commit; then commit
        send_byte(8'h05); send_frame();
        send_word(22'h0AAAAA); send_byte(8'h07); send_frame();
        check_all("R8");
        send_word(22'h155AA5); send_byte(8'h06); send_frame();
        check_all("R7 R8");

        // R9: glitches on the data line with serial clock low
        glitch_data();
        send_byte(8'h84);
        glitch_data();
        send_frame();
        check_all("R9");

        // R4: ones before a frame must not join ones after it
        send_byte(8'hC0); send_frame();
        check_all("R4");
        send_byte(8'h03); send_frame();
        check_all("R4");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule